// File: doc/BRIEF.md
# Occupancy-Flagged Address Queue

This block is a single-clock first-in first-out queue of 16 cell addresses that sits between a producer of addresses and an extraction scheduler. The oldest stored address is always visible on the read data output, so the scheduler can inspect it and pop it in the same cycle.

Alongside the data path the queue reports four occupancy indications: non-empty, exactly one entry, completely full, and a boost flag that rises once occupancy reaches a threshold supplied at run time. The scheduler uses the boost flag to give a congested queue more read slots. A threshold of 8 gives a half-full indication, and values from 4 to 6 tend to balance load better across several queues. A write that arrives while the queue is full and no read is taken is refused and raises a sticky overflow error, which stays set until software-independent logic pulses a clear input.

Top module: `occ_flag_fifo`

## Requirements
- R1: After rst_ni is released, nonempty_o, single_o, full_o and ovf_err_o are all 0.
- R2: Addresses leave in the order they were accepted; whenever nonempty_o is 1, rd_addr_o shows the oldest stored address, and a read (rd_en_i=1) pops it at the clock edge.
- R3: nonempty_o is 1 exactly when at least one address is stored.
- R4: single_o is 1 exactly when one address is stored.
- R5: full_o is 1 exactly when 16 addresses are stored.
- R6: boost_o is 1 exactly when the stored count is greater than or equal to the 4-bit mid_thr_i; a change of mid_thr_i takes effect in the same cycle (a threshold of 0 keeps boost_o at 1).
- R7: A write while full_o=1 and rd_en_i=0 is refused: the stored addresses and their order are unchanged, and ovf_err_o is 1 after that clock edge.
- R8: ovf_err_o stays 1 until a cycle with ovf_clr_i=1, after which it is 0; if a refused write and ovf_clr_i occur in the same cycle, ovf_err_o is 1 afterwards.
- R9: A read and a write in the same cycle while full are both accepted: full_o stays 1, no error is raised and order is kept.
- R10: A read while empty is ignored: the queue stays empty, and a later write is the next address delivered; a read and a write together on an empty queue store the written address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write request |
| wr_addr_i | input | ADDR_W (8) | Address to store |
| rd_en_i | input | 1 | Read (pop) request |
| rd_addr_o | output | ADDR_W (8) | Oldest stored address |
| mid_thr_i | input | 4 | Boost threshold |
| ovf_clr_i | input | 1 | Clears the overflow error |
| nonempty_o | output | 1 | At least one entry stored |
| single_o | output | 1 | Exactly one entry stored |
| full_o | output | 1 | All 16 entries stored |
| boost_o | output | 1 | Occupancy at or above threshold |
| ovf_err_o | output | 1 | Sticky overflow error |

## Verification
The properties assume every input is a known value at each rising edge and that rd_addr_o is only meaningful while nonempty_o is 1; they check flag consistency, refusal, stickiness and head stability rather than the full contents. The bench drives all inputs at the falling edge, holds them stable through the rising edge, and compares outputs against a queue model after every cycle. Stimulus deliberately reaches both extremes, reading an empty queue and writing a full one, with and without the opposite operation in the same cycle.

// File: rtl/occ_fifo_pkg.sv
package occ_fifo_pkg;
  typedef struct packed {
    logic full;
    logic nonempty;
    logic single;
    logic boost;
  } occ_flags_t;
endpackage

// File: rtl/occ_fifo_ctrl.sv
module occ_fifo_ctrl #(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  output logic             wr_ok_o,
  output logic             ovf_evt_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic [CNT_W-1:0] count_o
);
  logic is_full, is_empty, rd_ok;

  assign is_full   = (count_o == CNT_W'(DEPTH));
  assign is_empty  = (count_o == '0);
  assign rd_ok     = rd_en_i & ~is_empty;
  // a pop in the same cycle frees the slot the push needs
  assign wr_ok_o   = wr_en_i & (~is_full | rd_ok);
  assign ovf_evt_o = wr_en_i & is_full & ~rd_en_i;

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_o <= '0;
      rd_ptr_o <= '0;
      count_o  <= '0;
    end else begin
      if (wr_ok_o) wr_ptr_o <= next_ptr(wr_ptr_o);
      if (rd_ok)   rd_ptr_o <= next_ptr(rd_ptr_o);
      case ({wr_ok_o, rd_ok})
        2'b10:   count_o <= count_o + 1'b1;
        2'b01:   count_o <= count_o - 1'b1;
        default: count_o <= count_o;
      endcase
    end
  end
endmodule

// File: rtl/occ_fifo_mem.sv
module occ_fifo_mem #(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  wptr_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic [PTR_W-1:0]  rptr_i,
  output logic [ADDR_W-1:0] rdata_o
);
  logic [ADDR_W-1:0] slots [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) slots[wptr_i] <= wdata_i;
  end

  assign rdata_o = slots[rptr_i];
endmodule

// File: rtl/occ_fifo_flags.sv
module occ_fifo_flags
  import occ_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int THR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic             ovf_evt_i,
  input  logic             ovf_clr_i,
  output occ_flags_t       flags_o,
  output logic             err_o
);
  always_comb begin
    flags_o.full     = (count_i == CNT_W'(DEPTH));
    flags_o.nonempty = (count_i != '0);
    flags_o.single   = (count_i == CNT_W'(1));
    flags_o.boost    = (count_i >= CNT_W'(thr_i));
  end

  // new overflow wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_o <= 1'b0;
    else if (ovf_evt_i) err_o <= 1'b1;
    else if (ovf_clr_i) err_o <= 1'b0;
  end
endmodule

// File: rtl/occ_flag_fifo.sv
module occ_flag_fifo
  import occ_fifo_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int THR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              rd_en_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [THR_W-1:0]  mid_thr_i,
  input  logic              ovf_clr_i,
  output logic              nonempty_o,
  output logic              single_o,
  output logic              full_o,
  output logic              boost_o,
  output logic              ovf_err_o
);
  logic             wr_ok, ovf_evt;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  occ_flags_t       flags;

  occ_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i,
    .wr_ok_o(wr_ok), .ovf_evt_o(ovf_evt),
    .wr_ptr_o(wr_ptr), .rd_ptr_o(rd_ptr), .count_o(count)
  );

  occ_fifo_mem #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_mem (
    .clk_i, .we_i(wr_ok), .wptr_i(wr_ptr), .wdata_i(wr_addr_i),
    .rptr_i(rd_ptr), .rdata_o(rd_addr_o)
  );

  occ_fifo_flags #(.DEPTH(DEPTH)) u_flags (
    .clk_i, .rst_ni, .count_i(count), .thr_i(mid_thr_i),
    .ovf_evt_i(ovf_evt), .ovf_clr_i, .flags_o(flags), .err_o(ovf_err_o)
  );

  assign nonempty_o = flags.nonempty;
  assign single_o   = flags.single;
  assign full_o     = flags.full;
  assign boost_o    = flags.boost;
endmodule

// File: rtl/occ_flag_fifo_chk.sv
module occ_flag_fifo_chk #(
  parameter int ADDR_W = 8,
  parameter int THR_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic [THR_W-1:0]  mid_thr_i,
  input logic              ovf_clr_i,
  input logic              nonempty_o,
  input logic              single_o,
  input logic              full_o,
  input logic              boost_o,
  input logic              ovf_err_o
);
  // R2
  first_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nonempty_o && wr_en_i) |=> (single_o && rd_addr_o == $past(wr_addr_i)));
  // R4
  single_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    single_o |-> (nonempty_o && !full_o));
  // R5
  full_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> (nonempty_o && !single_o));
  // R6
  zero_thr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mid_thr_i == '0) |-> boost_o);
  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && full_o && !rd_en_i) |=> (ovf_err_o && full_o && $stable(rd_addr_o)));
  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_err_o && !ovf_clr_i) |=> ovf_err_o);
  // R9
  full_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_en_i && rd_en_i) |=> full_o);
  // R10
  empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nonempty_o && rd_en_i && !wr_en_i) |=> !nonempty_o);
endmodule

bind occ_flag_fifo occ_flag_fifo_chk #(.ADDR_W(ADDR_W), .THR_W(THR_W)) u_chk (.*);

// File: tb/occ_flag_fifo_tb.sv
module occ_flag_fifo_tb;
  localparam int AW = 8;
  localparam int DEPTH = 16;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          wr_en = 0, rd_en = 0, clr = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [3:0]    thr = 4'd8;
  logic [AW-1:0] rd_addr;
  logic          nonempty, single, full, boost, err;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  int mq[$];
  bit m_err = 0;

  always #5 clk = ~clk;

  occ_flag_fifo u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .rd_en_i(rd_en), .rd_addr_o(rd_addr), .mid_thr_i(thr), .ovf_clr_i(clr),
    .nonempty_o(nonempty), .single_o(single), .full_o(full),
    .boost_o(boost), .ovf_err_o(err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R3 nonempty", int'(nonempty), int'(mq.size() > 0));
    chk("R4 single",   int'(single),   int'(mq.size() == 1));
    chk("R5 full",     int'(full),     int'(mq.size() == DEPTH));
    chk("R6 boost",    int'(boost),    int'(mq.size() >= int'(thr)));
    chk("R8 err",      int'(err),      int'(m_err));
    if (mq.size() > 0) chk("R2 head", int'(rd_addr), mq[0]);
  endtask

  // one clock: drive at falling edge, update model, check after rising edge
  task automatic cyc(input bit w, input int a, input bit r, input bit c);
    bit rd_ok, wr_ok, ovf;
    @(negedge clk);
    wr_en = w; wr_addr = AW'(a); rd_en = r; clr = c;
    rd_ok = r && mq.size() > 0;
    wr_ok = w && (mq.size() < DEPTH || rd_ok);
    ovf   = w && mq.size() == DEPTH && !r;
    @(posedge clk);
    if (rd_ok) void'(mq.pop_front());
    if (wr_ok) mq.push_back(a);
    if (ovf) m_err = 1;
    else if (c) m_err = 0;
    #1;
    wr_en = 0; rd_en = 0; clr = 0;
    check_all();
  endtask

  task automatic drain();
    while (mq.size() > 0) cyc(0, 0, 1, 0);
  endtask

  task automatic t_reset();
    chk("R1 nonempty", int'(nonempty), 0);
    chk("R1 single",   int'(single),   0);
    chk("R1 full",     int'(full),     0);
    chk("R1 err",      int'(err),      0);
  endtask

  task automatic t_order();
    for (int i = 0; i < 5; i++) cyc(1, 8'h30 + i * 7, 0, 0);
    cyc(1, 8'hA5, 1, 0);          // R2 push and pop together
    cyc(0, 0, 1, 0);
    cyc(1, 8'h5A, 0, 0);
    drain();
  endtask

  task automatic t_fill_full();
    for (int i = 0; i < DEPTH; i++) cyc(1, 8'hC0 + i, 0, 0);
    chk("R5 full after 16", int'(full), 1);
  endtask

  task automatic t_overflow();
    cyc(1, 8'hEE, 0, 0);          // R7 refused write
    chk("R7 err set", int'(err), 1);
    cyc(1, 8'hEF, 0, 0);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R7 contents kept", int'(rd_addr), 8'hC0 + i);
      cyc(0, 0, 1, 0);
    end
    chk("R8 err held while idle", int'(err), 1);
  endtask

  task automatic t_clear();
    cyc(0, 0, 0, 1);
    chk("R8 cleared", int'(err), 0);
    for (int i = 0; i < DEPTH; i++) cyc(1, i, 0, 0);
    cyc(1, 8'h99, 0, 1);          // R8 overflow and clear together
    chk("R8 set beats clear", int'(err), 1);
    cyc(0, 0, 0, 1);
    chk("R8 clear after", int'(err), 0);
  endtask

  task automatic t_full_swap();
    for (int i = 0; i < 4; i++) cyc(1, 8'h70 + i, 1, 0);  // R9
    chk("R9 still full", int'(full), 1);
    chk("R9 no err", int'(err), 0);
    drain();
  endtask

  task automatic t_empty_read();
    cyc(0, 0, 1, 0);
    cyc(0, 0, 1, 0);
    chk("R10 empty after read", int'(nonempty), 0);
    cyc(1, 8'h11, 1, 0);          // R10 read ignored, write stored
    chk("R10 rw on empty", int'(rd_addr), 8'h11);
    cyc(1, 8'h22, 0, 0);
    drain();
  endtask

  task automatic t_threshold();
    int vals[5] = '{0, 4, 6, 8, 15};
    foreach (vals[k]) begin
      thr = 4'(vals[k]);
      drain();
      for (int i = 0; i < DEPTH; i++) cyc(1, i, 0, 0);
      for (int i = 0; i < DEPTH; i++) cyc(0, 0, 1, 0);
    end
    for (int i = 0; i < 5; i++) cyc(1, i, 0, 0);
    thr = 4'd5; #1; chk("R6 live thr 5", int'(boost), 1);
    thr = 4'd6; #1; chk("R6 live thr 6", int'(boost), 0);
    thr = 4'd8;
    drain();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1;
    @(posedge clk); #1 t_reset();
    t_order();
    t_fill_full();
    t_overflow();
    t_clear();
    t_full_swap();
    t_empty_read();
    t_threshold();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule